// File: doc/BRIEF.md
# Multiplexed-Address ROM with Block Decode

This block is a 2048-word by 8-bit read-only store meant to hang directly on a processor bus whose 16-bit address arrives in two halves over eight shared address lines. The high half comes first, framed by an address strobe. The block keeps that high byte in an internal latch, and the low half then sits on the same lines. The upper five latched bits pick one 2K block of the 64K space. A build-time parameter fixes which block answers. The word address joins the three low latched bits with the eight bits currently on the lines.

When the latched block matches and the chip-enable input is active, the block counts as selected and raises its chip-enable output. Further memory can be chained from this output. A byte is driven only while the block is selected, the memory-read input is active and both chip-select inputs are active. The block presents the byte as `bus_q` together with the enable `bus_oe`, and a pad ring turns that pair into a three-state bus. The active level of the strobe, the read input, the chip-enable input and each chip select is its own parameter. The contents come from a constant function of the word address and a seed parameter, with no file involved.

The latch is run by a three-state machine clocked by the system clock:
- `LAT_IDLE`: the state after reset.
- `LAT_OPEN`: the strobe is active and the high byte is being captured.
- `LAT_HELD`: a high byte has been committed.

The transitions are:
- `T_OPEN`: `LAT_IDLE` or `LAT_HELD` goes to `LAT_OPEN` when the strobe is sampled active.
- `T_COMMIT`: `LAT_OPEN` goes to `LAT_HELD` when the strobe is sampled inactive, which is the trailing edge.
- `T_STAY`: every other case keeps the state.

Top module: `mux_rom_bank`

## Requirements
- R1: While driving, `bus_q` equals `{w[2:0], w[7:3]} ^ {5'b0, w[10:8]} ^ ROM_SEED` for the 11-bit word address w.
- R2: The word address w is `{hi[2:0], addr_lines}`, where hi is the latched high byte and `addr_lines` is the value present in the current cycle.
- R3: The latch takes the value on `addr_lines` at the last clock edge where the strobe was sampled active. The value is committed at the first edge where the strobe is sampled inactive, and it is then held unchanged until the next such commit.
- R4: The block matches when hi[7:3] equals BLOCK.
- R5: `ce_out` is 1 exactly when the state is `LAT_HELD`, the block matches and the chip-enable input is active. It is 0 before the first commit and 0 while the machine is in `LAT_OPEN`.
- R6: `bus_oe` is 1 exactly when `ce_out` is 1, the read input is active and both chip selects are active. The chip selects have no effect on `ce_out`.
- R7: While `bus_oe` is 0, `bus_q` is 0.
- R8: Each control input counts as active when it is high if its `*_HI` parameter is 1, and when it is low if that parameter is 0.
- R9: During and right after reset, `ce_out` and `bus_oe` are 0 and the machine is in `LAT_IDLE`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the strobe |
| rst_n | input | 1 | Active-low synchronous reset |
| addr_lines | input | 8 | Multiplexed address: high byte, then low byte |
| strobe | input | 1 | High-address strobe, polarity set by STB_HI |
| rd_in | input | 1 | Memory-read, polarity set by RD_HI |
| ce_in | input | 1 | Chip-enable input, polarity set by CEI_HI |
| cs_a | input | 1 | First output-driver select, polarity set by CS1_HI |
| cs_b | input | 1 | Second output-driver select, polarity set by CS2_HI |
| bus_q | output | 8 | Data byte for the three-state pad, 0 when not driving |
| bus_oe | output | 1 | Pad driver enable, 1 when the bus is to be driven |
| ce_out | output | 1 | Chain enable, high while this block is selected |

## Verification
The bench runs two builds side by side: one with every control active high and block 3, the other with every control active low and block 30. High bytes are chosen to fall in one build's window, in the other's, or in neither, so a wrong compare or a wrong polarity shows as a select in the wrong build. Each of the four gating inputs is dropped on its own during an otherwise valid read. This tells the inputs that reach `ce_out` apart from the ones that only gate the drivers. The low byte is changed while a latch value is held, and a new strobe is started on top of an old one. Together these separate the live low half from the latched high half and show when a commit happens.

// File: rtl/mrom_pkg.sv
package mrom_pkg;

    localparam int DATA_W = 8;

    typedef enum logic [1:0] {
        LAT_IDLE = 2'd0,
        LAT_OPEN = 2'd1,
        LAT_HELD = 2'd2
    } lat_state_e;

    // Level of a control pin translated into "asserted"
    function automatic logic pin_on(input logic pin, input bit act_high);
        return act_high ? pin : ~pin;
    endfunction

    // Content of the store: byte for an 11-bit word address
    function automatic logic [DATA_W-1:0] rom_word(input logic [10:0] w,
                                                   input logic [DATA_W-1:0] seed);
        return {w[2:0], w[7:3]} ^ {5'b0, w[10:8]} ^ seed;
    endfunction

endpackage

// File: rtl/mrom_hi_latch.sv
module mrom_hi_latch
    import mrom_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter bit STB_HI = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strobe,
    input  logic [ADDR_W-1:0] addr_lines,
    output logic [ADDR_W-1:0] hi_q,
    output logic              held
);

    lat_state_e        state_q;
    lat_state_e        state_d;
    logic [ADDR_W-1:0] shadow_q;
    logic              stb_on;
    logic              commit;

    assign stb_on = pin_on(strobe, STB_HI);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= LAT_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state and commit decision
    always_comb begin
        state_d = state_q;
        commit  = 1'b0;
        unique case (state_q)
            LAT_IDLE: begin
                if (stb_on) state_d = LAT_OPEN;          // T_OPEN
            end
            LAT_OPEN: begin
                if (!stb_on) begin                       // T_COMMIT
                    state_d = LAT_HELD;
                    commit  = 1'b1;
                end
            end
            LAT_HELD: begin
                if (stb_on) state_d = LAT_OPEN;          // T_OPEN
            end
            default: state_d = LAT_IDLE;
        endcase
    end

    // capture while open, commit on trailing edge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shadow_q <= '0;
            hi_q     <= '0;
        end else begin
            if (stb_on) shadow_q <= addr_lines;
            if (commit) hi_q     <= shadow_q;
        end
    end

    assign held = (state_q == LAT_HELD);

endmodule

// File: rtl/mrom_select.sv
module mrom_select
    import mrom_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int BLK_W  = 5,
    parameter int BLOCK  = 0,
    parameter bit RD_HI  = 1'b0,
    parameter bit CEI_HI = 1'b1,
    parameter bit CS1_HI = 1'b0,
    parameter bit CS2_HI = 1'b1
) (
    input  logic              held,
    input  logic [ADDR_W-1:0] hi_q,
    input  logic              rd_in,
    input  logic              ce_in,
    input  logic              cs_a,
    input  logic              cs_b,
    output logic              sel,
    output logic              drive
);

    localparam logic [BLK_W-1:0] BLK_ID = BLK_W'(BLOCK);

    logic hit;
    logic gates_open;

    assign hit        = (hi_q[ADDR_W-1 -: BLK_W] == BLK_ID);
    assign gates_open = pin_on(rd_in, RD_HI) & pin_on(cs_a, CS1_HI) & pin_on(cs_b, CS2_HI);

    always_comb begin
        sel   = held & hit & pin_on(ce_in, CEI_HI);
        drive = sel & gates_open;
    end

endmodule

// File: rtl/mrom_store.sv
module mrom_store
    import mrom_pkg::*;
#(
    parameter int              WORD_W   = 11,
    parameter logic [DATA_W-1:0] ROM_SEED = 8'hA5
) (
    input  logic [WORD_W-1:0] word_addr,
    input  logic              drive,
    output logic [DATA_W-1:0] data_q
);

    always_comb begin
        data_q = drive ? rom_word(word_addr, ROM_SEED) : '0;
    end

endmodule

// File: rtl/mux_rom_bank.sv
module mux_rom_bank
    import mrom_pkg::*;
#(
    parameter int              ADDR_W   = 8,
    parameter int              WORD_W   = 11,
    parameter int              BLOCK    = 0,
    parameter logic [7:0]      ROM_SEED = 8'hA5,
    parameter bit              STB_HI   = 1'b1,
    parameter bit              RD_HI    = 1'b0,
    parameter bit              CEI_HI   = 1'b1,
    parameter bit              CS1_HI   = 1'b0,
    parameter bit              CS2_HI   = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_lines,
    input  logic              strobe,
    input  logic              rd_in,
    input  logic              ce_in,
    input  logic              cs_a,
    input  logic              cs_b,
    output logic [7:0]        bus_q,
    output logic              bus_oe,
    output logic              ce_out
);

    localparam int BLK_W = 2 * ADDR_W - WORD_W;
    localparam int LOW_W = WORD_W - ADDR_W;

    logic [ADDR_W-1:0] hi_q;
    logic              held;
    logic              sel;
    logic              drive;
    logic [WORD_W-1:0] word_addr;

    mrom_hi_latch #(
        .ADDR_W (ADDR_W),
        .STB_HI (STB_HI)
    ) u_latch (
        .clk        (clk),
        .rst_n      (rst_n),
        .strobe     (strobe),
        .addr_lines (addr_lines),
        .hi_q       (hi_q),
        .held       (held)
    );

    mrom_select #(
        .ADDR_W (ADDR_W),
        .BLK_W  (BLK_W),
        .BLOCK  (BLOCK),
        .RD_HI  (RD_HI),
        .CEI_HI (CEI_HI),
        .CS1_HI (CS1_HI),
        .CS2_HI (CS2_HI)
    ) u_select (
        .held  (held),
        .hi_q  (hi_q),
        .rd_in (rd_in),
        .ce_in (ce_in),
        .cs_a  (cs_a),
        .cs_b  (cs_b),
        .sel   (sel),
        .drive (drive)
    );

    assign word_addr = {hi_q[LOW_W-1:0], addr_lines};

    mrom_store #(
        .WORD_W   (WORD_W),
        .ROM_SEED (ROM_SEED)
    ) u_store (
        .word_addr (word_addr),
        .drive     (drive),
        .data_q    (bus_q)
    );

    assign bus_oe = drive;
    assign ce_out = sel;

endmodule

// File: rtl/mux_rom_bank_chk.sv
module mux_rom_bank_chk
    import mrom_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter bit STB_HI = 1'b1,
    parameter bit CEI_HI = 1'b1,
    parameter bit CS1_HI = 1'b0,
    parameter bit CS2_HI = 1'b1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              strobe,
    input logic              ce_in,
    input logic              cs_a,
    input logic              cs_b,
    input logic [7:0]        bus_q,
    input logic              bus_oe,
    input logic              ce_out,
    input logic [ADDR_W-1:0] hi_q
);

    logic stb_on;
    logic cei_on;
    logic cs_on;

    assign stb_on = pin_on(strobe, STB_HI);
    assign cei_on = pin_on(ce_in, CEI_HI);
    assign cs_on  = pin_on(cs_a, CS1_HI) & pin_on(cs_b, CS2_HI);

    AST_OE_NEEDS_SEL: assert property (@(posedge clk) disable iff (!rst_n)
        bus_oe |-> ce_out);                                                   // R6
    AST_OE_NEEDS_CS: assert property (@(posedge clk) disable iff (!rst_n)
        bus_oe |-> cs_on);                                                    // R6
    AST_QUIET_BUS: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_oe |-> (bus_q == 8'h00));                                        // R7
    AST_CE_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        ce_out |-> cei_on);                                                   // R5
    AST_NO_SEL_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(stb_on) && stb_on) |-> !ce_out);                               // R5
    AST_HOLD_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(stb_on, 2) || $past(stb_on)) |-> $stable(hi_q));              // R3

endmodule

bind mux_rom_bank mux_rom_bank_chk #(
    .ADDR_W (ADDR_W),
    .STB_HI (STB_HI),
    .CEI_HI (CEI_HI),
    .CS1_HI (CS1_HI),
    .CS2_HI (CS2_HI)
) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .strobe (strobe),
    .ce_in  (ce_in),
    .cs_a   (cs_a),
    .cs_b   (cs_b),
    .bus_q  (bus_q),
    .bus_oe (bus_oe),
    .ce_out (ce_out),
    .hi_q   (hi_q)
);

// File: tb/mux_rom_bank_test.sv
`timescale 1ns/1ps
module mux_rom_bank_test;

    localparam int BLK_A = 3;
    localparam int BLK_B = 30;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    // logical (asserted = 1) stimulus
    logic [7:0] addr = 8'h00;
    logic l_stb = 0, l_rd = 0, l_ce = 0, l_cs1 = 0, l_cs2 = 0;

    logic [7:0] q_a, q_b;
    logic       oe_a, oe_b, ce_a, ce_b;

    // build A: every control active high
    mux_rom_bank #(.BLOCK(BLK_A), .STB_HI(1'b1), .RD_HI(1'b1), .CEI_HI(1'b1),
                   .CS1_HI(1'b1), .CS2_HI(1'b1)) uut (
        .clk(clk), .rst_n(rst_n), .addr_lines(addr),
        .strobe(l_stb), .rd_in(l_rd), .ce_in(l_ce), .cs_a(l_cs1), .cs_b(l_cs2),
        .bus_q(q_a), .bus_oe(oe_a), .ce_out(ce_a));

    // build B: every control active low
    mux_rom_bank #(.BLOCK(BLK_B), .STB_HI(1'b0), .RD_HI(1'b0), .CEI_HI(1'b0),
                   .CS1_HI(1'b0), .CS2_HI(1'b0)) uut_b (
        .clk(clk), .rst_n(rst_n), .addr_lines(addr),
        .strobe(~l_stb), .rd_in(~l_rd), .ce_in(~l_ce), .cs_a(~l_cs1), .cs_b(~l_cs2),
        .bus_q(q_b), .bus_oe(oe_b), .ce_out(ce_b));

    int checks = 0;
    int fails  = 0;

    // behavioural reference
    bit       m_open, m_valid;
    int       m_shadow, m_latch;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_open = 0; m_valid = 0; m_shadow = 0; m_latch = 0;
        end else if (l_stb) begin
            m_shadow = addr; m_open = 1;
        end else if (m_open) begin
            m_latch = m_shadow; m_valid = 1; m_open = 0;
        end
    end

    function automatic int rom_ref(int w);
        return (((w % 8) * 32 + (w % 256) / 8) ^ (w / 256) ^ 8'hA5) & 255;
    endfunction

    function automatic bit exp_sel(int blk);
        return m_valid && !m_open && (m_latch / 8 == blk) && l_ce;
    endfunction

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
        end
    endtask

    task automatic cmp_one(string nm, int blk, bit ce, bit oe, logic [7:0] q);
        bit s, d;
        int w;
        s = exp_sel(blk);
        d = s && l_rd && l_cs1 && l_cs2;
        w = (m_latch % 8) * 256 + addr;
        chk({nm, (rst_n ? " R5 ce_out" : " R9 ce_out")}, ce, s);
        chk({nm, " R6 bus_oe"}, oe, d);
        chk({nm, (d ? " R1 bus_q" : " R7 bus_q")}, q, d ? rom_ref(w) : 0);
    endtask

    // per-cycle comparison against the model (R8 via the two polarity builds)
    always @(negedge clk) begin
        cmp_one("A", BLK_A, ce_a, oe_a, q_a);
        cmp_one("B", BLK_B, ce_b, oe_b, q_b);
    end

    task automatic tick;
        @(posedge clk);
        #1;
    endtask

    // one multiplexed bus cycle, ends with the low byte on the lines
    task automatic bus_cycle(input logic [7:0] hi, input logic [7:0] lo,
                             input bit rd, input bit ce, input bit c1, input bit c2);
        addr = hi; l_stb = 1; l_rd = 0;
        tick; tick;
        l_stb = 0; addr = lo; l_rd = rd; l_ce = ce; l_cs1 = c1; l_cs2 = c2;
        tick; tick;
    endtask

    // watchdog
    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks + 1);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R9 reset ce_out A", ce_a, 0);
        chk("R9 reset bus_oe B", oe_b, 0);
        tick;
        rst_n = 1;
        tick; tick;
        // before first commit: nothing selected even with all gates on
        l_ce = 1; l_rd = 1; l_cs1 = 1; l_cs2 = 1; addr = 8'h1A;
        @(negedge clk);
        chk("R5 no select before commit", ce_a, 0);
        tick;

        // in A's window (block 3): A drives
        bus_cycle(8'h1A, 8'h34, 1, 1, 1, 1);
        @(negedge clk);
        chk("R4 A selected in window", ce_a, 1);
        chk("R4 B not selected", ce_b, 0);
        chk("R2 A word 0x234", q_a, rom_ref(32'h234));
        // R3: low byte changes, latch held
        addr = 8'hC7;
        @(negedge clk);
        chk("R3 R2 latch held new low", q_a, rom_ref(32'h2C7));
        tick;

        // in B's window (block 30)
        bus_cycle(8'hF5, 8'h09, 1, 1, 1, 1);
        @(negedge clk);
        chk("R8 B active-low selected", ce_b, 1);
        chk("R8 B drives", oe_b, 1);
        chk("R4 A out of window", ce_a, 0);

        // outside both windows
        bus_cycle(8'h40, 8'h55, 1, 1, 1, 1);
        @(negedge clk);
        chk("R4 none selected A", ce_a, 0);
        chk("R4 none selected B", ce_b, 0);

        // each gate dropped alone, in A's window
        bus_cycle(8'h1F, 8'hAA, 1, 0, 1, 1);
        @(negedge clk);
        chk("R5 ce_in off", ce_a, 0);
        bus_cycle(8'h1F, 8'hAA, 0, 1, 1, 1);
        @(negedge clk);
        chk("R6 read off keeps ce_out", ce_a, 1);
        chk("R6 read off no drive", oe_a, 0);
        bus_cycle(8'h1F, 8'hAA, 1, 1, 0, 1);
        @(negedge clk);
        chk("R6 cs_a off keeps ce_out", ce_a, 1);
        chk("R7 cs_a off quiet bus", q_a, 0);
        bus_cycle(8'h1F, 8'hAA, 1, 1, 1, 0);
        @(negedge clk);
        chk("R6 cs_b off no drive", oe_a, 0);

        // R3: new strobe over a held value deselects, commits on trailing edge
        bus_cycle(8'h18, 8'h01, 1, 1, 1, 1);
        addr = 8'h40; l_stb = 1;
        tick;
        @(negedge clk);
        chk("R5 deselected while open", ce_a, 0);
        addr = 8'h1B; tick;
        l_stb = 0; addr = 8'h02;
        @(negedge clk);
        chk("R3 no commit before edge", ce_a, 0);
        tick;
        @(negedge clk);
        chk("R3 last strobe byte committed", q_a, rom_ref(32'h302));

        // sweep every high byte with varied low bytes
        for (int h = 0; h < 256; h += 3) begin
            bus_cycle(8'(h), 8'(h * 7 + 13), 1, 1, (h % 5) != 0, 1);
        end

        l_rd = 0; l_ce = 0;
        tick; tick;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule